// File: doc/BRIEF.md
# Infrared Receive Frame Status Queue

This block sits behind an infrared serial receiver and keeps one record for every frame the receiver finishes. Each record holds the frame's length in bytes (13 bits) and three error indications: a bad CRC, a physical-layer error, and a flag that the frame was longer than a programmable maximum. The receiver raises a one-cycle frame-done strobe with the length and error inputs valid. The block compares the length against the configured maximum at that moment and stores the result with the record.

Software reaches the queue through a byte-wide read port with four addresses: a status byte, the low and high bytes of the oldest record's length, and a lost-frame counter. A read of the high length byte retires the oldest record and brings the next one forward. When a frame completes while every slot is occupied, the frame is not stored. The block counts it, raises a sticky lost-frame flag and raises a status-queue overrun flag. A pulse from the receive data FIFO sets a separate data overrun flag.

Top module: `irrx_frame_status_queue`

## Requirements
- R1: After reset the status byte (address 0), both length bytes (addresses 1 and 2) and the lost-frame counter (address 3) all read 0.
- R2: Status bit 7 (ready) reads 1 exactly when at least one record is queued. Records are presented oldest first.
- R3: Address 1 returns length bits 7:0 of the oldest record. Address 2 returns length bits 12:8 in its bits 4:0, and its bits 7:5 read 0.
- R4: A read of address 2 while ready is 1 removes the oldest record. Reads of addresses 0, 1 and 3 never remove a record.
- R5: A read of address 2 while ready is 0 returns 0 and leaves the queue unchanged.
- R6: Status bit 3 (physical error) and bit 2 (CRC error) return the oldest record's captured inputs. Bit 4 returns 1 when that record's length was strictly greater than the maximum {max_len_hi, max_len_lo} at push time.
- R7: While ready is 0, status bits 4:2 and both length bytes read 0.
- R8: A frame-done strobe while all DEPTH slots are full discards that frame, even if a pop happens in the same cycle. It sets status bit 6 (lost frame) and bit 0 (status-queue overrun), and it increments the counter at address 3.
- R9: The lost-frame counter saturates at 2^CNT_W-1.
- R10: A read of address 0 returns the current flags and then clears bits 6, 1 and 0 and the lost-frame counter. If a new event arrives in the same cycle, the event wins over the clear.
- R11: A data_ovr pulse sets status bit 1 (receive-data overrun), which stays set until cleared as in R10.
- R12: Status bit 5 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_done | input | 1 | One-cycle strobe: a frame has completed |
| frame_len | input | 13 | Byte length of the completed frame |
| crc_bad | input | 1 | Completed frame had a bad CRC |
| phy_bad | input | 1 | Completed frame had a physical-layer error |
| data_ovr | input | 1 | Pulse: receive data FIFO overran |
| max_len_lo | input | 8 | Maximum frame length, bits 7:0 |
| max_len_hi | input | 5 | Maximum frame length, bits 12:8 |
| rd_en | input | 1 | Register read strobe, side effects applied at the clock edge |
| rd_addr | input | 2 | 0 status, 1 length low, 2 length high (pops), 3 lost counter |
| rd_data | output | 8 | Read data for rd_addr |

## Verification
The bench builds the queue with DEPTH of 4 and CNT_W of 3. With these values the full-queue loss path is reached after four frames, and counter saturation at 7 is reached after a handful of extra frames. The stimulus table holds two full queue loads, so pointer wraparound is exercised. Maximum-length comparison is exercised just below, at and just above the threshold.

// File: rtl/irrx_fsq_pkg.sv
package irrx_fsq_pkg;
   localparam int FLEN_W = 13;

   typedef struct packed {
      logic              phy;
      logic              crc;
      logic              over;
      logic [FLEN_W-1:0] len;
   } fsq_entry_t;

   localparam int ENTRY_W = $bits(fsq_entry_t);

   typedef enum logic [1:0] {
      A_STAT  = 2'd0,
      A_LENLO = 2'd1,
      A_LENHI = 2'd2,
      A_LOST  = 2'd3
   } fsq_addr_e;
endpackage

// File: rtl/irrx_fsq_fifo.sv
module irrx_fsq_fifo #(
   parameter int DEPTH = 8,
   parameter int W     = 16,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   input  logic [W-1:0]  din,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty
);
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [W-1:0]  mem [DEPTH];
   logic          do_push, do_pop;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [W-1:0] q;
      always_ff @(posedge clk) begin
         if (do_push && (wr_ptr == AW'(i))) q <= din;
      end
      assign mem[i] = q;
   end

   assign dout = mem[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + AW'(1);
         if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
         case ({do_push, do_pop})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/irrx_fsq_lost.sv
module irrx_fsq_lost #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lose,
   input  logic             data_ovr,
   input  logic             clr,
   output logic             lost_flag,
   output logic             sq_ovr,
   output logic             rx_ovr,
   output logic [CNT_W-1:0] lost_cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lost_flag <= 1'b0;
         sq_ovr    <= 1'b0;
         rx_ovr    <= 1'b0;
         lost_cnt  <= '0;
      end else begin
         lost_flag <= lose || (lost_flag && !clr);
         sq_ovr    <= lose || (sq_ovr && !clr);
         rx_ovr    <= data_ovr || (rx_ovr && !clr);
         if (clr)
            lost_cnt <= lose ? CNT_W'(1) : '0;
         else if (lose && lost_cnt != CNT_MAX)
            lost_cnt <= lost_cnt + CNT_W'(1);
      end
   end
endmodule

// File: rtl/irrx_frame_status_queue.sv
module irrx_frame_status_queue
   import irrx_fsq_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int CNT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_done,
   input  logic [12:0]       frame_len,
   input  logic              crc_bad,
   input  logic              phy_bad,
   input  logic              data_ovr,
   input  logic [7:0]        max_len_lo,
   input  logic [4:0]        max_len_hi,
   input  logic              rd_en,
   input  logic [1:0]        rd_addr,
   output logic [7:0]        rd_data
);
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (CNT_W < 1 || CNT_W > 8) begin : g_bad_cnt
      $error("CNT_W must fit the byte-wide read port");
   end

   fsq_entry_t        push_e, head;
   logic [CW-1:0]     q_count;
   logic              q_full, q_empty;
   logic              lost_flag, sq_ovr, rx_ovr;
   logic [CNT_W-1:0]  lost_cnt;
   logic              pop_rd, stat_rd, lose, ready;

   assign pop_rd  = rd_en && (rd_addr == A_LENHI);
   assign stat_rd = rd_en && (rd_addr == A_STAT);
   assign lose    = frame_done && q_full;
   assign ready   = !q_empty;

   always_comb begin
      push_e.phy  = phy_bad;
      push_e.crc  = crc_bad;
      push_e.over = frame_len > {max_len_hi, max_len_lo};
      push_e.len  = frame_len;
   end

   irrx_fsq_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (frame_done),
      .pop   (pop_rd),
      .din   (push_e),
      .dout  (head),
      .count (q_count),
      .full  (q_full),
      .empty (q_empty)
   );

   irrx_fsq_lost #(.CNT_W(CNT_W)) u_lost (
      .clk       (clk),
      .rst_n     (rst_n),
      .lose      (lose),
      .data_ovr  (data_ovr),
      .clr       (stat_rd),
      .lost_flag (lost_flag),
      .sq_ovr    (sq_ovr),
      .rx_ovr    (rx_ovr),
      .lost_cnt  (lost_cnt)
   );

   always_comb begin
      case (fsq_addr_e'(rd_addr))
         A_STAT:  rd_data = {ready, lost_flag, 1'b0, ready && head.over,
                             ready && head.phy, ready && head.crc, rx_ovr, sq_ovr};
         A_LENLO: rd_data = ready ? head.len[7:0] : 8'h00;
         A_LENHI: rd_data = ready ? {3'b000, head.len[12:8]} : 8'h00;
         default: rd_data = 8'(lost_cnt);
      endcase
   end
endmodule

// File: rtl/irrx_fsq_chk.sv
module irrx_fsq_chk #(
   parameter int DEPTH = 8,
   parameter int CNT_W = 8,
   parameter int CW    = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             frame_done,
   input logic             data_ovr,
   input logic             rd_en,
   input logic [1:0]       rd_addr,
   input logic [7:0]       rd_data,
   input logic [CW-1:0]    q_count,
   input logic             q_full,
   input logic             q_empty,
   input logic             lost_flag,
   input logic             sq_ovr,
   input logic             rx_ovr,
   input logic [CNT_W-1:0] lost_cnt
);
   localparam logic [CNT_W-1:0] CMAX = '1;

   // R2
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q_count <= CW'(DEPTH));

   // R4
   pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr == 2'd2 && !q_empty && !frame_done)
      |=> q_count == $past(q_count) - CW'(1));

   // R5
   empty_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr == 2'd2 && q_empty) |-> rd_data == 8'h00);

   // R8
   lost_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && q_full) |=> (lost_flag && sq_ovr && q_count == CW'(DEPTH)));

   // R9
   sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lost_cnt == CMAX && !(rd_en && rd_addr == 2'd0)) |=> lost_cnt == CMAX);

   // R10
   stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr == 2'd0 && !frame_done && !data_ovr)
      |=> (!lost_flag && !sq_ovr && !rx_ovr && lost_cnt == '0));

   // R11
   rx_ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_ovr |=> rx_ovr);

   // R12
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == 2'd0) |-> !rd_data[5]);
endmodule

bind irrx_frame_status_queue irrx_fsq_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W), .CW(CW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .frame_done (frame_done),
   .data_ovr   (data_ovr),
   .rd_en      (rd_en),
   .rd_addr    (rd_addr),
   .rd_data    (rd_data),
   .q_count    (q_count),
   .q_full     (q_full),
   .q_empty    (q_empty),
   .lost_flag  (lost_flag),
   .sq_ovr     (sq_ovr),
   .rx_ovr     (rx_ovr),
   .lost_cnt   (lost_cnt)
);

// File: tb/irrx_frame_status_queue_bench.sv
`timescale 1ns/1ps
module irrx_frame_status_queue_bench;
   localparam int DEPTH = 4;
   localparam int CNT_W = 3;
   localparam int MAXL  = 300;
   localparam int NV    = 8;
   // each vector: {phy, crc, len[12:0]}
   localparam logic [14:0] VEC [NV] = '{
      {1'b0, 1'b0, 13'd5},    {1'b0, 1'b1, 13'd300},
      {1'b1, 1'b0, 13'd301},  {1'b0, 1'b0, 13'd8191},
      {1'b1, 1'b1, 13'd0},    {1'b0, 1'b0, 13'd256},
      {1'b0, 1'b1, 13'd4660}, {1'b1, 1'b0, 13'd299}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_done = 1'b0;
   logic [12:0] frame_len = '0;
   logic        crc_bad = 1'b0, phy_bad = 1'b0, data_ovr = 1'b0;
   logic [7:0]  max_len_lo = 8'(MAXL);
   logic [4:0]  max_len_hi = 5'(MAXL >> 8);
   logic        rd_en = 1'b0;
   logic [1:0]  rd_addr = '0;
   logic [7:0]  rd_data;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   irrx_frame_status_queue #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_irrx_frame_status_queue (
      .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .frame_len(frame_len),
      .crc_bad(crc_bad), .phy_bad(phy_bad), .data_ovr(data_ovr),
      .max_len_lo(max_len_lo), .max_len_hi(max_len_hi),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data));

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic push(input logic [12:0] len, input logic crc, input logic phy);
      @(negedge clk);
      frame_done = 1'b1; frame_len = len; crc_bad = crc; phy_bad = phy;
      @(negedge clk);
      frame_done = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      rd_en = 1'b1; rd_addr = a;
      #1 d = rd_data;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   function automatic logic [7:0] exp_stat(input logic [14:0] v);
      return {1'b1, 2'b00, (v[12:0] > 13'(MAXL)), v[14], v[13], 2'b00};
   endfunction

   initial begin
      #(4 * 20000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd(2'd0, d); chk("R1 status", d, 8'h00);
      rd(2'd1, d); chk("R1 lenlo", d, 8'h00);
      rd(2'd2, d); chk("R1 lenhi", d, 8'h00);
      rd(2'd3, d); chk("R1 lost count", d, 8'h00);

      // table walk: R2 R3 R4 R6 R12
      for (int base = 0; base < NV; base += DEPTH) begin
         for (int i = 0; i < DEPTH; i++) push(VEC[base+i][12:0], VEC[base+i][13], VEC[base+i][14]);
         for (int i = 0; i < DEPTH; i++) begin
            rd(2'd0, d); chk("R6 R12 status", d, exp_stat(VEC[base+i]));
            rd(2'd1, d); chk("R3 lenlo", d, VEC[base+i][7:0]);
            rd(2'd2, d); chk("R3 lenhi", d, {3'b000, VEC[base+i][12:8]});
         end
         rd(2'd0, d); chk("R2 drained", d, 8'h00);
      end

      // R5 empty high read has no effect
      rd(2'd2, d); chk("R5 empty hi", d, 8'h00);
      push(13'd77, 1'b0, 1'b0);
      rd(2'd1, d); chk("R5 single entry", d, 8'd77);
      rd(2'd2, d);
      rd(2'd0, d); chk("R5 R7 empty again", d, 8'h00);
      rd(2'd1, d); chk("R7 lenlo empty", d, 8'h00);

      // R4 non-popping reads
      push(13'd10, 1'b1, 1'b0);
      push(13'd20, 1'b0, 1'b0);
      rd(2'd1, d); rd(2'd0, d); rd(2'd3, d); rd(2'd1, d);
      chk("R4 no pop", d, 8'd10);
      rd(2'd2, d);
      rd(2'd1, d); chk("R4 pop", d, 8'd20);
      rd(2'd2, d);

      // R8 full queue loss, R9 saturation
      for (int i = 1; i <= DEPTH; i++) push(13'(i), 1'b0, 1'b0);
      push(13'd100, 1'b1, 1'b1);
      rd(2'd3, d); chk("R8 lost count", d, 8'd1);
      for (int i = 0; i < 9; i++) push(13'd100, 1'b0, 1'b0);
      rd(2'd3, d); chk("R9 saturated", d, 8'd7);
      rd(2'd0, d); chk("R8 status flags", d, 8'hC1);
      rd(2'd0, d); chk("R10 cleared", d, 8'h80);
      rd(2'd3, d); chk("R10 count cleared", d, 8'h00);
      for (int i = 1; i <= DEPTH; i++) begin
         rd(2'd1, d); chk("R8 kept entry", d, 8'(i));
         rd(2'd2, d);
      end

      // R11 data overrun sticky
      @(negedge clk); data_ovr = 1'b1;
      @(negedge clk); data_ovr = 1'b0;
      rd(2'd0, d); chk("R11 rx overrun", d, 8'h02);
      rd(2'd0, d); chk("R11 R10 cleared", d, 8'h00);

      // R10 event wins over clear in the same cycle
      @(negedge clk); rd_en = 1'b1; rd_addr = 2'd0; data_ovr = 1'b1;
      #1 d = rd_data;
      @(negedge clk); rd_en = 1'b0; data_ovr = 1'b0;
      chk("R10 pre value", d, 8'h00);
      rd(2'd0, d); chk("R10 set wins", d, 8'h02);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule